// File: doc/BRIEF.md
# Host-Clocked Serial Result Port

This block is the digital output side of a successive-approximation converter whose serial port is clocked by the host. A conversion starts on a pulse of `conv_start_i`. The block then holds `busy_o` high for a programmable number of system clock cycles. When `busy_o` falls, the block captures the word on `result_i`. The host reads the captured word on `sdout_o` by toggling `sclk_i` while both `cs_ni` and `rd_ni` are low.

All inputs are synchronous to `clk_i`. The block finds edges on `sclk_i` by sampling it, so the serial clock can be continuous or gated, and can rest high or low between bursts. The host samples `sdout_o` just before each `sclk_i` rising edge. The port updates `sdout_o` on falling edges and samples the chain input on rising edges.

There are two read modes, chosen by `mode_i`, which is latched when a conversion starts:
- **Read after conversion** (mode 0): the host reads once `busy_o` is low. Bits on `chain_i` are shifted in behind the local word, so several ports can be cascaded.
- **Read during conversion** (mode 1): the host reads the previous result while the next conversion runs. A one-cycle `rderror_o` pulse reports a read that was not finished when `busy_o` fell.

Top module: `adc_sport`

## Requirements
- R1: After reset, `busy_o`, `sdout_o` and `rderror_o` are low.
- R2: A `conv_start_i` pulse while `busy_o` is low raises `busy_o` on the next cycle. `busy_o` then stays high for exactly `busy_cycles_i` cycles, and a value of 0 counts as 1. A `conv_start_i` pulse while `busy_o` is high is ignored.
- R3: While `cs_ni` or `rd_ni` is high, `sdout_o` is low and `sclk_i` edges do not advance the read position.
- R4: A read presents the 18-bit word most significant bit first. The value of `sdout_o` sampled before the k-th `sclk_i` rising edge (k from 1) is bit 18-k. This holds whether `sclk_i` rests low or high between bursts.
- R5: In mode 0 (mode encoding: 0 = read after conversion, 1 = read during conversion), `sdout_o` stays low and `sclk_i` is ignored while `busy_o` is high. The new word is readable from the cycle in which `busy_o` falls.
- R6: In mode 0, `chain_i` is sampled on each `sclk_i` rising edge. The bit sampled on rising edge j appears on `sdout_o` before rising edge 18+j, directly after the local LSB.
- R7: In mode 1, `chain_i` is ignored, and `sdout_o` reads 0 once all 18 bits have been presented.
- R8: In mode 1, a read during a conversion returns the word captured at the end of the previous conversion. The read position restarts at the MSB when the conversion starts.
- R9: In mode 1, if fewer than 18 `sclk_i` rising edges were accepted between the start and the end of the conversion, `rderror_o` is high for exactly the one cycle in which `busy_o` falls. A rising edge seen in that same cycle is not counted. Mode 0 never raises `rderror_o`.
- R10: Taking `cs_ni` high and low again restarts the read at the MSB.
- R11: The mode is the value of `mode_i` when the conversion starts. Later changes of `mode_i` have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_start_i | input | 1 | Conversion start pulse |
| busy_cycles_i | input | 12 | Conversion length in clock cycles |
| mode_i | input | 1 | 0 = read after conversion, 1 = read during conversion |
| result_i | input | 18 | Word captured at the end of a conversion |
| sclk_i | input | 1 | Host serial clock, sampled |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read enable, active low |
| chain_i | input | 1 | Cascade data from an upstream port |
| busy_o | output | 1 | Conversion in progress |
| sdout_o | output | 1 | Serial data out |
| rderror_o | output | 1 | Incomplete read pulse |

## Verification
The collision that matters is an `sclk_i` rising edge that lands in the same clock cycle as the end of a mode-1 conversion. In that cycle, the read counter would advance at the same time as the word reload and the error decision. The bench times the 18th rising edge to the exact cycle in which `busy_o` falls and expects a `rderror_o` pulse, because that last edge is lost to the reload. It then moves the same edge one cycle earlier and expects no pulse. Random reads cover partial and complete reads in both modes, with either resting level of `sclk_i`.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;
  typedef enum logic {
    RD_AFTER  = 1'b0,
    RD_DURING = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/sport_edge_det.sv
module sport_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sig_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_q[g] <= 1'b0;
      else         sig_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
    assign fall_o[g] = ~sig_i[g] & sig_q[g];
  end
endmodule

// File: rtl/sport_conv_timer.sv
module sport_conv_timer
  import adc_sport_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] cycles_i,
  input  rd_mode_e      mode_i,
  output logic          busy_o,
  output logic          go_o,
  output logic          end_o,
  output rd_mode_e      mode_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  rd_mode_e      mode_q;

  assign go_o  = start_i & ~busy_q;
  assign end_o = busy_q & (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= RD_AFTER;
    end else if (go_o) begin
      busy_q <= 1'b1;
      cnt_q  <= (cycles_i == '0) ? CW'(1) : cycles_i;
      mode_q <= mode_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
      if (end_o) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter #(
  parameter int unsigned DW = 18,
  localparam int unsigned BCW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          shift_en_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          load_i,
  input  logic          restart_i,
  input  logic [DW-1:0] word_i,
  input  logic          chain_en_i,
  input  logic          chain_i,
  output logic          out_o,
  output logic          full_o
);
  logic [DW-1:0]  hold_q;
  logic [DW-1:0]  sr_q;
  logic [BCW-1:0] bit_cnt_q;
  logic           out_q;
  logic           full_q;
  logic           in_bit;

  assign in_bit = chain_en_i & chain_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (load_i) hold_q <= word_i;
  end

  // priority: capture > conversion restart > deselect > shifting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      bit_cnt_q <= '0;
      out_q     <= 1'b0;
      full_q    <= 1'b0;
    end else if (load_i) begin
      sr_q      <= word_i;
      out_q     <= word_i[DW-1];
      bit_cnt_q <= '0;
      full_q    <= 1'b0;
    end else if (restart_i) begin
      sr_q      <= hold_q;
      out_q     <= hold_q[DW-1];
      bit_cnt_q <= '0;
      full_q    <= 1'b0;
    end else if (!sel_i) begin
      sr_q      <= hold_q;
      out_q     <= hold_q[DW-1];
      bit_cnt_q <= '0;
    end else if (shift_en_i) begin
      if (rise_i) begin
        sr_q <= {sr_q[DW-2:0], in_bit};
        if (bit_cnt_q != BCW'(DW)) bit_cnt_q <= bit_cnt_q + BCW'(1);
        if (bit_cnt_q == BCW'(DW - 1)) full_q <= 1'b1;
      end
      if (fall_i) out_q <= sr_q[DW-1];
    end
  end

  assign out_o  = out_q;
  assign full_o = full_q;
endmodule

// File: rtl/adc_sport.sv
module adc_sport
  import adc_sport_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          conv_start_i,
  input  logic [CW-1:0] busy_cycles_i,
  input  logic          mode_i,
  input  logic [DW-1:0] result_i,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          chain_i,
  output logic          busy_o,
  output logic          sdout_o,
  output logic          rderror_o
);
  localparam int unsigned EW = 1;

  logic     busy, conv_go, conv_end, sel, vis, sr_out, full, rderr_q;
  logic     mode_q;
  rd_mode_e mode_e;
  rd_mode_e mode_in;
  logic [EW-1:0] rise, fall;

  assign mode_in = rd_mode_e'(mode_i);

  sport_edge_det #(.W(EW)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  sport_conv_timer #(.CW(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (conv_start_i),
    .cycles_i (busy_cycles_i),
    .mode_i   (mode_in),
    .busy_o   (busy),
    .go_o     (conv_go),
    .end_o    (conv_end),
    .mode_o   (mode_e)
  );

  assign mode_q = (mode_e == RD_DURING);
  assign sel    = ~cs_ni & ~rd_ni;
  // after-conversion reads are blocked while converting
  assign vis    = mode_q | ~busy;

  sport_shifter #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .shift_en_i (vis),
    .rise_i     (rise[0]),
    .fall_i     (fall[0]),
    .load_i     (conv_end),
    .restart_i  (conv_go & (mode_in == RD_DURING)),
    .word_i     (result_i),
    .chain_en_i (~mode_q),
    .chain_i    (chain_i),
    .out_o      (sr_out),
    .full_o     (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rderr_q <= 1'b0;
    else         rderr_q <= conv_end & mode_q & ~full;
  end

  assign busy_o    = busy;
  assign sdout_o   = sel & vis & sr_out;
  assign rderror_o = rderr_q;
endmodule

// File: rtl/adc_sport_chk.sv
module adc_sport_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_start_i,
  input logic cs_ni,
  input logic rd_ni,
  input logic busy_o,
  input logic sdout_o,
  input logic rderror_o,
  input logic mode_q
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && conv_start_i) |=> busy_o); // R2
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> !sdout_o); // R3
  AST_AFTER_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mode_q) |-> !sdout_o); // R5
  AST_RDERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rderror_o |=> !rderror_o); // R9
  AST_RDERR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rderror_o |-> $fell(busy_o)); // R9
  AST_RDERR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rderror_o |-> mode_q); // R9
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mode_q)); // R11
endmodule

bind adc_sport adc_sport_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_start_i (conv_start_i),
  .cs_ni        (cs_ni),
  .rd_ni        (rd_ni),
  .busy_o       (busy_o),
  .sdout_o      (sdout_o),
  .rderror_o    (rderror_o),
  .mode_q       (mode_q)
);

// File: tb/adc_sport_bench.sv
module adc_sport_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic [11:0] busy_cycles = '0;
  logic        mode = 1'b0;
  logic [17:0] result = '0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        chain = 1'b0;
  logic        busy, sdout, rderr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_sport u_adc_sport (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_i(conv_start), .busy_cycles_i(busy_cycles),
    .mode_i(mode), .result_i(result), .sclk_i(sclk), .cs_ni(cs_n), .rd_ni(rd_n),
    .chain_i(chain), .busy_o(busy), .sdout_o(sdout), .rderror_o(rderr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_seq(input logic [17:0] w, input logic [63:0] ch,
                                          input int nb, input bit after);
    logic [63:0] r = '0;
    for (int i = 0; i < nb; i++) r[i] = (i < 18) ? w[17-i] : (after ? ch[i-18] : 1'b0);
    return r;
  endfunction

  task automatic start_conv(input int n, input bit m, input logic [17:0] w, output int s);
    conv_start = 1'b1; busy_cycles = 12'(n); mode = m; result = w;
    s = cyc + 1;
    tick(1);
    conv_start = 1'b0;
  endtask

  task automatic wait_end(output int len, output bit err, input int s);
    while (busy) tick(1);
    len = cyc - s;
    err = rderr;
    tick(1);
    check(!rderr, "R9", "rderror width", 64'(rderr), 64'd0);
  endtask

  task automatic do_read(input int nb, input bit idle_hi, input logic [63:0] ch,
                         output logic [63:0] got);
    got = '0;
    sclk = idle_hi; tick(1);
    cs_n = 1'b0; rd_n = 1'b0; tick(2);
    for (int i = 0; i < nb; i++) begin
      if (idle_hi) begin sclk = 1'b0; tick(2); end
      got[i] = sdout; chain = ch[i]; sclk = 1'b1; tick(2);
      if (!idle_hi) begin sclk = 1'b0; tick(2); end
    end
  endtask

  task automatic deselect();
    cs_n = 1'b1; rd_n = 1'b1; tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] prev, w;
    logic [63:0] got, ch;
    int s, len, n, k;
    bit err, m, ih;
    void'($urandom(32'h5eed_0a17));
    tick(3);
    check(!busy && !sdout && !rderr, "R1", "reset outputs", {busy, sdout, rderr}, 0);
    rst_n = 1'b1; tick(2);

    // R2 start ignored while busy, and zero length
    start_conv(20, 0, 18'h2a5c3, s); tick(5);
    conv_start = 1'b1; busy_cycles = 12'd3; tick(1); conv_start = 1'b0;
    wait_end(len, err, s);
    check(len == 20, "R2", "busy length, restart ignored", 64'(len), 20);
    prev = 18'h2a5c3;
    start_conv(0, 0, 18'h3ffff, s); wait_end(len, err, s);
    check(len == 1, "R2", "zero length", 64'(len), 1);
    prev = 18'h3ffff;

    // R3 deselected edges ignored
    w = 18'h1b2c4; start_conv(10, 0, w, s); wait_end(len, err, s); prev = w;
    cs_n = 1'b1; rd_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      sclk = ~sclk; chain = 1'b1; tick(2);
      check(!sdout, "R3", "cs high quiet", 64'(sdout), 0);
    end
    cs_n = 1'b0; rd_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sclk = ~sclk; tick(2);
      check(!sdout, "R3", "rd high quiet", 64'(sdout), 0);
    end
    deselect(); sclk = 1'b0;
    do_read(18, 0, 0, got); deselect();
    check(got == exp_seq(w, 0, 18, 1), "R3", "read after ignored edges", got, exp_seq(w, 0, 18, 1));

    // R10 partial read then restart from MSB
    do_read(7, 1, 0, got); deselect();
    do_read(18, 0, 0, got); deselect();
    check(got == exp_seq(w, 0, 18, 1), "R10", "restart at MSB", got, exp_seq(w, 0, 18, 1));

    // R5 after mode quiet during busy, R11 mode held
    w = 18'h0f0f3; start_conv(40, 0, w, s);
    tick(1); mode = 1'b1;
    cs_n = 1'b0; rd_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      sclk = ~sclk; tick(2);
      check(!sdout, "R5", "after mode busy quiet", 64'(sdout), 0);
    end
    sclk = 1'b0; deselect();
    wait_end(len, err, s);
    check(!err, "R11", "no rderror after mode change", 64'(err), 0);
    prev = w;
    do_read(22, 0, 64'hb, got); deselect();
    check(got == exp_seq(w, 64'hb, 22, 1), "R11", "chain still active", got, exp_seq(w, 64'hb, 22, 1));

    // R9 collision: 18th edge in end cycle is lost
    n = 120; w = 18'h15555; start_conv(n, 1, w, s);
    do_read(17, 0, 0, got);
    check(got == exp_seq(prev, 0, 17, 0), "R8", "previous word", got, exp_seq(prev, 0, 17, 0));
    while (cyc < s + n - 1) tick(1);
    sclk = 1'b1; tick(1);
    check(!busy && rderr, "R9", "edge at end not counted", {busy, rderr}, 2'b01);
    sclk = 1'b0; tick(1); deselect(); prev = w;
    w = 18'h2aaaa; start_conv(n, 1, w, s);
    do_read(17, 0, 0, got);
    while (cyc < s + n - 2) tick(1);
    sclk = 1'b1; tick(2);
    check(!busy && !rderr, "R9", "edge before end counted", {busy, rderr}, 2'b00);
    sclk = 1'b0; tick(1); deselect(); prev = w;

    // random mix
    for (int it = 0; it < 30; it++) begin
      m = 1'($urandom % 2); ih = 1'($urandom % 2);
      w = 18'($urandom); ch = {$urandom, $urandom};
      if (!m) begin
        n = 3 + int'($urandom % 40);
        start_conv(n, 0, w, s); wait_end(len, err, s);
        check(len == n, "R2", "busy length", 64'(len), 64'(n));
        check(!err, "R9", "no rderror in mode 0", 64'(err), 0);
        prev = w;
        k = 18 + int'($urandom % 9);
        do_read(k, ih, ch, got); deselect();
        check(got == exp_seq(w, ch, k, 1), "R6", "mode 0 read with chain", got, exp_seq(w, ch, k, 1));
        check(got[17:0] == exp_seq(w, ch, 18, 1), "R4", "MSB first", got[17:0], exp_seq(w, ch, 18, 1));
      end else begin
        n = 110 + int'($urandom % 100);
        k = ($urandom % 3 == 0) ? int'($urandom % 18) : 18 + int'($urandom % 5);
        start_conv(n, 1, w, s);
        do_read(k, ih, ch, got); deselect();
        check(got == exp_seq(prev, ch, k, 0), "R7", "mode 1 read, chain ignored", got, exp_seq(prev, ch, k, 0));
        wait_end(len, err, s);
        check(err == (k < 18), "R9", "rderror vs bits read", 64'(err), 64'(k < 18));
        prev = w;
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule